// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block sits between a processor request port and a plain word-addressed memory port. It keeps a small data cache with two lines in each set. Each request address is split into three fields. The low bits pick a word inside a line, the middle bits pick a set, and the remaining upper bits form the tag. The tags of both lines in the addressed set are compared in parallel. Each set holds one recency bit, which records the line used most recently, so the other line is the one replaced on a fill.

Writes work in one of two ways. In write-back operation a write updates only the cache and marks the line dirty, and the line goes back to memory when it is evicted. A mode input switches to write-through operation, where every write also reaches memory. Two maintenance commands drop the whole cache. The first simply discards every line. The second first writes out every dirty line and then discards the contents.

Top module: `sa2_cache`

## Requirements
- R1: Address bits [WORD_BITS-1:0] select the word in a line. Bits [WORD_BITS+SET_BITS-1:WORD_BITS] select the set. The remaining upper bits are the tag. Block number b = addr >> WORD_BITS lives only in set b mod 2^SET_BITS, so blocks in different sets never displace each other.
- R2: A read of a cached word returns the stored value and makes no memory transfer. At most one line of the set matches the tag.
- R3: Each access to a line marks it most recently used in its set. A fill goes into an invalid line if the set has one, and otherwise into the line not most recently used.
- R4: A read miss fetches all 2^WORD_BITS words of the block, one word per memory beat. Only after that does it return the requested word.
- R5: With mode input wt_mode=0 (write-back), a write hit changes only the cache. It makes no memory transfer and marks the line dirty.
- R6: An evicted line is written to memory as 2^WORD_BITS write beats before the fill, if and only if the line is dirty. Clean lines are dropped with no write.
- R7: With wt_mode=1 (write-through), every write makes exactly one memory write beat with the request address and data. A hit also updates the cached copy.
- R8: A write-through write miss writes memory only and allocates no line, so a later read of that block misses.
- R9: A write-back write miss allocates the line: it fetches the block, then merges the write data and marks the line dirty.
- R10: Command code 2 invalidates every line with no memory write. Dirty data is lost, and later accesses miss.
- R11: Command code 3 writes every dirty line back to memory, then invalidates every line.
- R12: Command codes 0 and 1 are read and write. A request is accepted on a clock edge where cpu_req and cpu_ready are both high. cpu_ready stays low until the one-cycle cpu_done pulse that ends the request. Memory address, direction and data hold steady while a beat waits for mem_ack.
- R13: After reset all lines are invalid and clean, cpu_ready is high and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_cmd | input | 2 | 0 read, 1 write, 2 invalidate all, 3 write back then invalidate |
| cpu_addr | input | ADDR_W (10) | Word address |
| cpu_wdata | input | DATA_W (16) | Write data |
| wt_mode | input | 1 | 1 selects write-through, 0 write-back |
| cpu_ready | output | 1 | Ready to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W (16) | Read data, valid with cpu_done |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W (10) | Memory word address |
| mem_wdata | output | DATA_W (16) | Memory write data |
| mem_rdata | input | DATA_W (16) | Memory read data |
| mem_ack | input | 1 | Beat completes on this edge |

## Verification
Some properties are checked on every cycle. Both lines of a set never match the same tag at once. A dirty bit never sits on an invalid line, and a freshly filled line is valid and clean. An accessed line becomes most recent, and an invalidate leaves no valid line. The completion pulse lasts one cycle, and memory beats hold steady until acknowledged.

Other behaviour only shows across whole request sequences, so the bench scenarios cover it. These include the choice of victim, whether a write-back happens on eviction, no-allocate write-through misses, loss of dirty data on invalidate, and memory contents after a flush. For every request the bench compares the number of read and write beats, and the returned data, with a behavioural model of per-set recency lists.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_INVAL = 2'd2,
    CMD_FLUSH = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_WTWR,
    ST_SCAN,
    ST_DRAIN,
    ST_CLEAR
  } state_e;
endpackage

// File: rtl/sa2_tag_way.sv
module sa2_tag_way #(
  parameter int SET_BITS = 2,
  parameter int TAG_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] idx,
  input  logic [TAG_W-1:0]    cmp_tag,
  input  logic                fill_en,
  input  logic                dirty_set,
  input  logic                dirty_clr,
  input  logic                clr_all,
  output logic                hit,
  output logic                valid,
  output logic                dirty,
  output logic [TAG_W-1:0]    tag
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [SETS];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (clr_all) begin
      valid_d = '0;
      dirty_d = '0;
    end else begin
      if (fill_en) begin
        valid_d[idx] = 1'b1;
        dirty_d[idx] = 1'b0;
      end
      if (dirty_set) dirty_d[idx] = 1'b1;
      if (dirty_clr) dirty_d[idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= cmp_tag;
  end

  assign valid = valid_q[idx];
  assign dirty = dirty_q[idx];
  assign tag   = tag_q[idx];
  assign hit   = valid_q[idx] && (tag_q[idx] == cmp_tag);

  // R10
  inval_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_q == '0));

  // R6
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0);

  // R4
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !clr_all) |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));
endmodule

// File: rtl/sa2_data_way.sv
module sa2_data_way #(
  parameter int SET_BITS  = 2,
  parameter int WORD_BITS = 2,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [SET_BITS+WORD_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [SET_BITS+WORD_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int ENTRIES = 1 << (SET_BITS + WORD_BITS);

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/sa2_use_bits.sv
module sa2_use_bits #(
  parameter int SET_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_en,
  input  logic [SET_BITS-1:0] touch_set,
  input  logic                touch_way,
  input  logic                clr_all,
  input  logic [SET_BITS-1:0] rd_set,
  output logic                mru_way
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0] mru_q, mru_d;

  always_comb begin
    mru_d = mru_q;
    if (clr_all)       mru_d = '0;
    else if (touch_en) mru_d[touch_set] = touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mru_q <= '0;
    else        mru_q <= mru_d;
  end

  assign mru_way = mru_q[rd_set];

  // R3
  lru_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !clr_all) |=> (mru_q[$past(touch_set)] == $past(touch_way)));
endmodule

// File: rtl/sa2_cache.sv
module sa2_cache
  import sa2_cache_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int SET_BITS  = 2,
  parameter int WORD_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_cmd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              wt_mode,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W = ADDR_W - SET_BITS - WORD_BITS;
  localparam int NWAYS = 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  state_e                st_q, st_d;
  cmd_e                  cmd_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     wdata_q;
  logic                  wt_q;
  logic [WORD_BITS-1:0]  beat_q, beat_d;
  logic [SET_BITS:0]     line_q, line_d;
  logic                  vict_q, vict_d;
  logic                  done_d;
  logic [DATA_W-1:0]     rdata_d;
  logic                  accept;

  logic [TAG_W-1:0]      req_tag;
  logic [SET_BITS-1:0]   req_set, rd_set;
  logic [WORD_BITS-1:0]  req_word, rd_word, wr_word;
  logic                  flushing, sel_way, hit_way, any_hit, vic_pick, mru_way;

  logic [NWAYS-1:0]      way_hit, way_valid, way_dirty;
  logic [NWAYS-1:0]      fill_en, dirty_set, dirty_clr, data_we;
  logic [TAG_W-1:0]      way_tag   [NWAYS];
  logic [DATA_W-1:0]     way_rdata [NWAYS];
  logic                  clr_all, touch_en;
  logic [DATA_W-1:0]     data_wdata;

  assign req_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign req_set  = addr_q[WORD_BITS +: SET_BITS];
  assign req_word = addr_q[WORD_BITS-1:0];
  assign flushing = (st_q == ST_SCAN) || (st_q == ST_DRAIN);
  assign rd_set   = flushing ? line_q[SET_BITS-1:0] : req_set;
  assign sel_way  = flushing ? line_q[SET_BITS] : vict_q;
  assign rd_word  = ((st_q == ST_EVICT) || (st_q == ST_DRAIN)) ? beat_q : req_word;
  assign wr_word  = (st_q == ST_FILL) ? beat_q : req_word;
  assign data_wdata = (st_q == ST_FILL) ? mem_rdata : wdata_q;
  assign any_hit  = |way_hit;
  assign hit_way  = way_hit[1];
  assign vic_pick = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : ~mru_way);
  assign accept   = (st_q == ST_IDLE) && cpu_req;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    sa2_tag_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_tag (
      .clk(clk), .rst_n(rst_ni), .idx(rd_set), .cmp_tag(req_tag),
      .fill_en(fill_en[w]), .dirty_set(dirty_set[w]), .dirty_clr(dirty_clr[w]),
      .clr_all(clr_all), .hit(way_hit[w]), .valid(way_valid[w]),
      .dirty(way_dirty[w]), .tag(way_tag[w])
    );
    sa2_data_way #(.SET_BITS(SET_BITS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W)) u_data (
      .clk(clk), .wr_en(data_we[w]), .wr_idx({req_set, wr_word}),
      .wr_data(data_wdata), .rd_idx({rd_set, rd_word}), .rd_data(way_rdata[w])
    );
  end

  sa2_use_bits #(.SET_BITS(SET_BITS)) u_use (
    .clk(clk), .rst_n(rst_ni), .touch_en(touch_en), .touch_set(req_set),
    .touch_way(hit_way), .clr_all(clr_all), .rd_set(rd_set), .mru_way(mru_way)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    line_d    = line_q;
    vict_d    = vict_q;
    done_d    = 1'b0;
    rdata_d   = '0;
    fill_en   = '0;
    dirty_set = '0;
    dirty_clr = '0;
    data_we   = '0;
    clr_all   = 1'b0;
    touch_en  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          line_d = '0;
          unique case (cmd_e'(cpu_cmd))
            CMD_INVAL: st_d = ST_CLEAR;
            CMD_FLUSH: st_d = ST_SCAN;
            default:   st_d = ST_LOOKUP;
          endcase
        end
      end
      ST_LOOKUP: begin
        if (any_hit) begin
          touch_en = 1'b1;
          if (cmd_q == CMD_READ) begin
            done_d  = 1'b1;
            rdata_d = way_rdata[hit_way];
            st_d    = ST_IDLE;
          end else begin
            data_we[hit_way] = 1'b1;
            if (wt_q) begin
              st_d = ST_WTWR;
            end else begin
              dirty_set[hit_way] = 1'b1;
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end
        end else if ((cmd_q == CMD_WRITE) && wt_q) begin
          st_d = ST_WTWR;
        end else begin
          vict_d = vic_pick;
          beat_d = '0;
          st_d   = (way_valid[vic_pick] && way_dirty[vic_pick]) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {way_tag[sel_way], rd_set, beat_q};
        mem_wdata = way_rdata[sel_way];
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (&beat_q) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag, req_set, beat_q};
        if (mem_ack) begin
          data_we[vict_q] = 1'b1;
          beat_d = beat_q + 1'b1;
          if (&beat_q) begin
            fill_en[vict_q] = 1'b1;
            st_d = ST_LOOKUP;
          end
        end
      end
      ST_WTWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_SCAN: begin
        if (way_valid[sel_way] && way_dirty[sel_way]) begin
          beat_d = '0;
          st_d   = ST_DRAIN;
        end else if (&line_q) begin
          st_d = ST_CLEAR;
        end else begin
          line_d = line_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {way_tag[sel_way], rd_set, beat_q};
        mem_wdata = way_rdata[sel_way];
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (&beat_q) begin
            dirty_clr[sel_way] = 1'b1;
            if (&line_q) begin
              st_d = ST_CLEAR;
            end else begin
              line_d = line_q + 1'b1;
              st_d   = ST_SCAN;
            end
          end
        end
      end
      ST_CLEAR: begin
        clr_all = 1'b1;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      beat_q   <= '0;
      line_q   <= '0;
      vict_q   <= 1'b0;
      cpu_done <= 1'b0;
    end else begin
      st_q     <= st_d;
      beat_q   <= beat_d;
      line_q   <= line_d;
      vict_q   <= vict_d;
      cpu_done <= done_d;
    end
  end

  // request capture and read data, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      cmd_q   <= cmd_e'(cpu_cmd);
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      wt_q    <= wt_mode;
    end
    if (done_d) cpu_rdata <= rdata_d;
  end

  assign cpu_ready = (st_q == ST_IDLE) && rst_ni;

  // R2
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_LOOKUP) |-> $onehot0(way_hit));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_done |=> !cpu_done);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_ready |-> !mem_req);
endmodule

// File: tb/sa2_cache_tb.sv
module sa2_cache_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int SBITS  = 2;
  localparam int WBITS  = 2;
  localparam int SETS   = 1 << SBITS;
  localparam int WORDS  = 1 << WBITS;
  localparam int MSIZE  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_req;
  logic [1:0]        cpu_cmd;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              wt_mode;
  logic              cpu_ready, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  sa2_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_BITS(SBITS), .WORD_BITS(WBITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_cmd(cpu_cmd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .wt_mode(wt_mode),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: one word per beat, acknowledge on alternate cycles
  logic [DATA_W-1:0] mem_arr [MSIZE];
  bit                mem_wr  [MSIZE];
  bit                ack_en = 1'b0;
  int                rd_beats = 0;
  int                wr_beats = 0;

  function automatic logic [DATA_W-1:0] seed_val(input int a);
    return DATA_W'(a * 37 + 165);
  endfunction

  function automatic logic [DATA_W-1:0] mem_get(input int a);
    return mem_wr[a] ? mem_arr[a] : seed_val(a);
  endfunction

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = mem_get(int'(mem_addr));

  always @(posedge clk) begin
    ack_en <= ~ack_en;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem_arr[mem_addr] <= mem_wdata;
        mem_wr[mem_addr]  <= 1'b1;
        wr_beats++;
      end else begin
        rd_beats++;
      end
    end
  end

  // behavioural reference: per-set recency list, slot 0 most recent
  int                m_blk [SETS][2];
  bit                m_dty [SETS][2];
  int                m_n   [SETS];
  logic [DATA_W-1:0] golden [MSIZE];

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_access(input bit we, input int addr, input bit wt, output int erd, output int ewr);
    int s, b, pos;
    bit d;
    b = addr >> WBITS;
    s = b % SETS;
    pos = -1;
    erd = 0;
    ewr = 0;
    for (int i = 0; i < m_n[s]; i++) if (m_blk[s][i] == b) pos = i;
    if (pos >= 0) begin
      d = m_dty[s][pos];
      if (pos == 1) begin
        m_blk[s][1] = m_blk[s][0];
        m_dty[s][1] = m_dty[s][0];
        m_blk[s][0] = b;
        m_dty[s][0] = d;
      end
      if (we) begin
        if (wt) ewr = 1;
        else    m_dty[s][0] = 1'b1;
      end
    end else if (we && wt) begin
      ewr = 1;
    end else begin
      if (m_n[s] == 2) begin
        if (m_dty[s][1]) ewr = WORDS;
        m_n[s] = 1;
      end
      m_blk[s][1] = m_blk[s][0];
      m_dty[s][1] = m_dty[s][0];
      m_blk[s][0] = b;
      m_dty[s][0] = we;
      m_n[s]++;
      erd = WORDS;
    end
  endtask

  // issue one request and compare the outcome with the model
  task automatic run(input logic [1:0] cmd, input int addr, input int wd, input bit wt, input string req);
    int erd, ewr, base_rd, base_wr, n;
    erd = 0;
    ewr = 0;
    if (cmd == 2'd0 || cmd == 2'd1) begin
      model_access(cmd == 2'd1, addr, wt, erd, ewr);
      if (cmd == 2'd1) golden[addr] = DATA_W'(wd);
    end else begin
      for (int s = 0; s < SETS; s++)
        for (int i = 0; i < m_n[s]; i++)
          if (m_dty[s][i]) begin
            if (cmd == 2'd3) ewr += WORDS;
            else for (int k = 0; k < WORDS; k++)
              golden[m_blk[s][i]*WORDS + k] = mem_get(m_blk[s][i]*WORDS + k);
          end
      for (int s = 0; s < SETS; s++) m_n[s] = 0;
    end
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R12", "ready before request", int'(cpu_ready), 1);
    cpu_req   = 1'b1;
    cpu_cmd   = cmd;
    cpu_addr  = ADDR_W'(addr);
    cpu_wdata = DATA_W'(wd);
    wt_mode   = wt;
    base_rd   = rd_beats;
    base_wr   = wr_beats;
    @(negedge clk);
    cpu_req = 1'b0;
    n = 0;
    while (!cpu_done && n < 2000) begin
      if (cpu_ready) chk(1'b0, "R12", "ready while busy", 1, 0);
      @(negedge clk);
      n++;
    end
    chk(cpu_done == 1'b1, req, "completion", int'(cpu_done), 1);
    chk(rd_beats - base_rd == erd, req, "read beats", rd_beats - base_rd, erd);
    chk(wr_beats - base_wr == ewr, req, "write beats", wr_beats - base_wr, ewr);
    if (cmd == 2'd0)
      chk(cpu_rdata == golden[addr], req, "read data", int'(cpu_rdata), int'(golden[addr]));
    @(negedge clk);
    chk(cpu_done == 1'b0, "R12", "done pulse width", int'(cpu_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    for (int a = 0; a < MSIZE; a++) golden[a] = seed_val(a);
    for (int s = 0; s < SETS; s++) m_n[s] = 0;
    rst_n     = 1'b0;
    cpu_req   = 1'b0;
    cpu_cmd   = 2'd0;
    cpu_addr  = '0;
    cpu_wdata = '0;
    wt_mode   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(cpu_ready == 1'b1, "R13", "ready after reset", int'(cpu_ready), 1);
    chk(mem_req == 1'b0, "R13", "no memory request", int'(mem_req), 0);
    chk(cpu_done == 1'b0, "R13", "no done", int'(cpu_done), 0);

    // set 0 blocks: 0x000, 0x010, 0x020, 0x030; set 1: 0x004, 0x044
    run(2'd0, 'h001, 0, 0, "R4");      // cold miss, full block fetch
    run(2'd0, 'h002, 0, 0, "R2");      // hit, no traffic
    run(2'd0, 'h004, 0, 0, "R1");      // other set
    run(2'd0, 'h003, 0, 0, "R1");      // set 0 line untouched
    run(2'd1, 'h001, 'h1111, 0, "R5"); // write-back hit
    run(2'd0, 'h010, 0, 0, "R3");      // fills the free way
    run(2'd0, 'h000, 0, 0, "R3");      // still cached
    run(2'd0, 'h020, 0, 0, "R6");      // evicts clean 0x010
    run(2'd0, 'h001, 0, 0, "R5");      // cached copy holds new data
    run(2'd0, 'h010, 0, 0, "R3");      // evicts 0x020, the older line
    run(2'd0, 'h020, 0, 0, "R6");      // evicts dirty 0x000
    chk(mem_get('h001) == 16'h1111, "R6", "written back word", int'(mem_get('h001)), 'h1111);
    run(2'd1, 'h031, 'h7777, 0, "R9"); // allocate on write miss
    run(2'd0, 'h031, 0, 0, "R9");
    chk(mem_get('h031) != 16'h7777, "R9", "memory untouched", int'(mem_get('h031)), 0);
    run(2'd1, 'h022, 'h2222, 1, "R7"); // write-through hit
    chk(mem_get('h022) == 16'h2222, "R7", "memory updated", int'(mem_get('h022)), 'h2222);
    run(2'd0, 'h022, 0, 1, "R7");
    run(2'd1, 'h044, 'h6666, 1, "R8"); // write-through miss, no allocate
    chk(mem_get('h044) == 16'h6666, "R8", "memory updated", int'(mem_get('h044)), 'h6666);
    run(2'd0, 'h044, 0, 0, "R8");      // must miss
    run(2'd1, 'h004, 'h3333, 0, "R5");
    run(2'd1, 'h032, 'h4444, 0, "R5");
    run(2'd3, 0, 0, 0, "R11");         // flush dirty lines
    chk(mem_get('h004) == 16'h3333, "R11", "flushed word", int'(mem_get('h004)), 'h3333);
    chk(mem_get('h032) == 16'h4444, "R11", "flushed word", int'(mem_get('h032)), 'h4444);
    run(2'd0, 'h004, 0, 0, "R11");     // empty after flush
    run(2'd1, 'h011, 'h5555, 0, "R10");
    run(2'd2, 0, 0, 0, "R10");         // discard, no writes
    run(2'd0, 'h011, 0, 0, "R10");     // old memory value returns
    chk(cpu_rdata != 16'h5555, "R10", "dirty data dropped", int'(cpu_rdata), 0);
    for (int i = 0; i < 6; i++) begin  // thrash three blocks in one set
      run(2'd1, 'h100 + (i % 3) * 'h40, 'h0a00 + i, 0, "R6");
      run(2'd0, 'h100 + ((i + 1) % 3) * 'h40, 0, 0, "R3");
    end
    run(2'd3, 0, 0, 0, "R11");
    for (int k = 0; k < 3; k++)
      chk(mem_get('h100 + k * 'h40) == golden['h100 + k * 'h40], "R11", "final memory",
          int'(mem_get('h100 + k * 'h40)), int'(golden['h100 + k * 'h40]));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule